// File: doc/BRIEF.md
# USB Host Bridge Power-Up Reset Sequencer

This block is a self-running state machine that takes a USB host bridge from reset to operation without software involvement. A single start pulse sets off a fixed series of steps. It first puts the PHY, the host controller core and the bridge logic into reset. It then prepares and checks the controller clock divider. Next it turns on the reference clocking and the PHY power in one step. After that it releases the three resets in a fixed order, with a wait of ten controller-clock cycles between the bridge, core and host-mode steps. The PHY comes out of reset last.

Time is counted on a controller-clock enable strobe and not on the fast system clock. The waits therefore follow the real controller clock, whatever the ratio between the two clocks. If the divider does not report ready when it is checked, the sequence stops. It raises a sticky error and leaves every reset asserted. The remaining configuration values are sampled from input pins at the step that applies them: divider ratio, reference select, port-power enable and polarity, and endian mode.

Top module: `usb_host_bringup_seq`

## Requirements
- R1: While rstN is low, phyRst, coreRst and bridgeRst are 1. devMode is 1. Every other output is 0: divRst, divSel, hostClkEn, refSel, sscEn, refSspEn, hsPwrEn, ssPwrEn, ppcEn, ppcActiveHigh, ifClkEn, bigEndian, seqDone and seqError.
- R2: Take the clock edge at which startPulse is sampled high while the sequencer is idle. At that edge seqError clears. One edge later phyRst, coreRst and bridgeRst are all 1 together.
- R3: Two edges after the start edge, divRst becomes 1. One edge after that, divSel takes divSelCfg and hostClkEn becomes 1. The next edge is the readback check, which samples divReady. If divReady is 1, divRst returns to 0 one edge after the check.
- R4: One edge after divRst is released, a single edge applies all of the following together: refSel takes refSelCfg, and sscEn, refSspEn, hsPwrEn and ssPwrEn all become 1. All three domain resets are still asserted at that point.
- R5: Each of the three waits counts only edges at which ctrlClkStb is 1, and ends on the 10th such edge (parameter WAIT_CYCLES). The count starts after the edge that began the wait.
- R6: bridgeRst falls to 0 one edge after the 10th strobe that follows the power step.
- R7: The second wait starts at the bridge release and ends on its 10th strobe. One edge after that, ppcEn takes ppcEnCfg and ppcActiveHigh takes ppcActiveHighCfg (1 = active-high power output). On the next edge coreRst falls to 0.
- R8: The third wait starts at the core release and ends on its 10th strobe. One edge after that, ifClkEn becomes 1 and devMode becomes 0 (0 = host mode).
- R9: One edge after host mode is set, bigEndian takes bigEndianCfg (0 = little endian, 1 = big endian). On the next edge phyRst falls to 0, and seqDone is 1 for exactly that one cycle.
- R10: If divReady is 0 at the check edge, seqError becomes 1 and the sequencer returns to idle with every reset still asserted and divRst still 1. seqError stays 1 until the next accepted start.
- R11: A startPulse that arrives while a sequence is running has no effect on any output or on the step timing.
- R12: A start after a finished or failed sequence runs the whole sequence again from the reset-assert step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Begin a bring-up sequence (accepted only when idle) |
| ctrlClkStb | input | 1 | One-cycle enable marking a controller-clock cycle |
| divReady | input | 1 | Divider readback matches the programmed ratio |
| divSelCfg | input | 3 | Divider ratio code to apply |
| refSelCfg | input | 2 | Reference clock selection to apply |
| ppcEnCfg | input | 1 | Port-power control enable to apply |
| ppcActiveHighCfg | input | 1 | Port-power polarity to apply, 1 = active-high |
| bigEndianCfg | input | 1 | Endian mode to apply, 1 = big endian |
| phyRst | output | 1 | PHY reset, active high |
| coreRst | output | 1 | Host controller core reset, active high |
| bridgeRst | output | 1 | Bridge logic reset, active high |
| divRst | output | 1 | Controller clock divider reset, active high |
| divSel | output | 3 | Applied divider ratio code |
| hostClkEn | output | 1 | Controller clock enable |
| refSel | output | 2 | Applied reference clock selection |
| sscEn | output | 1 | Spread-spectrum enable |
| refSspEn | output | 1 | SuperSpeed reference enable |
| hsPwrEn | output | 1 | High-speed PHY power enable |
| ssPwrEn | output | 1 | SuperSpeed PHY power enable |
| ppcEn | output | 1 | Port-power control enable |
| ppcActiveHigh | output | 1 | Port-power polarity, 1 = active-high |
| ifClkEn | output | 1 | Interface clock enable |
| devMode | output | 1 | Controller mode, 0 = host, 1 = device |
| bigEndian | output | 1 | Endian mode, 1 = big endian |
| seqDone | output | 1 | One-cycle pulse when the PHY reset is released |
| seqError | output | 1 | Sticky divider-check failure |

## Verification
The bench builds the block with its default parameters: a three-bit divider code, a two-bit reference select and ten-strobe waits. With these values the four-bit wait counter reaches its last value, 9, in every wait. A full sequence fits in a few hundred cycles, even with sparse strobes. The bench drives the strobe three ways: every cycle, every third cycle, and from a pseudo-random pattern. The waits therefore see both back-to-back and gapped controller cycles. Further runs cover a failed divider check, start pulses that land mid-sequence, and a restart after an error.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ASSERT,
    S_DIVRST,
    S_DIVCFG,
    S_CHECK,
    S_DIVREL,
    S_PWR,
    S_WAIT_BR,
    S_BRREL,
    S_WAIT_CORE,
    S_PPC,
    S_COREREL,
    S_WAIT_HOST,
    S_HOST,
    S_ENDIAN,
    S_PHYREL
  } seq_state_e;

  // Strobes from the control FSM to the datapath, one cycle each
  typedef struct packed {
    logic assertAll;
    logic setDivRst;
    logic applyDiv;
    logic relDiv;
    logic applyPwr;
    logic relBridge;
    logic applyPpc;
    logic relCore;
    logic applyHost;
    logic applyEndian;
    logic relPhy;
    logic clrWait;
    logic cntWait;
    logic setErr;
    logic clrErr;
  } seq_cmd_t;

endpackage

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startPulse,
  input  logic     divReady,
  input  logic     waitDone,
  output seq_cmd_t cmd
);

  seq_state_e state;
  seq_state_e nextState;

  always_comb begin
    cmd       = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (startPulse) begin
          cmd.clrErr = 1'b1;
          nextState  = S_ASSERT;
        end
      end
      S_ASSERT: begin
        cmd.assertAll = 1'b1;
        nextState     = S_DIVRST;
      end
      S_DIVRST: begin
        cmd.setDivRst = 1'b1;
        nextState     = S_DIVCFG;
      end
      S_DIVCFG: begin
        cmd.applyDiv = 1'b1;
        nextState    = S_CHECK;
      end
      S_CHECK: begin
        if (divReady) begin
          nextState = S_DIVREL;
        end else begin
          cmd.setErr = 1'b1;
          nextState  = S_IDLE;
        end
      end
      S_DIVREL: begin
        cmd.relDiv = 1'b1;
        nextState  = S_PWR;
      end
      S_PWR: begin
        cmd.applyPwr = 1'b1;
        cmd.clrWait  = 1'b1;
        nextState    = S_WAIT_BR;
      end
      S_WAIT_BR: begin
        cmd.cntWait = 1'b1;
        if (waitDone) nextState = S_BRREL;
      end
      S_BRREL: begin
        cmd.relBridge = 1'b1;
        cmd.clrWait   = 1'b1;
        nextState     = S_WAIT_CORE;
      end
      S_WAIT_CORE: begin
        cmd.cntWait = 1'b1;
        if (waitDone) nextState = S_PPC;
      end
      S_PPC: begin
        cmd.applyPpc = 1'b1;
        nextState    = S_COREREL;
      end
      S_COREREL: begin
        cmd.relCore = 1'b1;
        cmd.clrWait = 1'b1;
        nextState   = S_WAIT_HOST;
      end
      S_WAIT_HOST: begin
        cmd.cntWait = 1'b1;
        if (waitDone) nextState = S_HOST;
      end
      S_HOST: begin
        cmd.applyHost = 1'b1;
        nextState     = S_ENDIAN;
      end
      S_ENDIAN: begin
        cmd.applyEndian = 1'b1;
        nextState       = S_PHYREL;
      end
      S_PHYREL: begin
        cmd.relPhy = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  // R2: an idle start always enters the reset-assert step
  a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && startPulse) |=> state == S_ASSERT);

  // R11: a start during a wait neither restarts nor skips the wait
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT_BR && startPulse && !waitDone) |=> state == S_WAIT_BR);

  // R10: a failed check returns to idle
  a_r10_fail_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHECK && !divReady) |=> state == S_IDLE);

endmodule

// File: rtl/pwrseq_dp.sv
module pwrseq_dp
  import pwrseq_pkg::*;
#(
  parameter int DIV_W       = 3,
  parameter int REF_W       = 2,
  parameter int WAIT_CYCLES = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_cmd_t         cmd,
  input  logic             ctrlClkStb,
  input  logic [DIV_W-1:0] divSelCfg,
  input  logic [REF_W-1:0] refSelCfg,
  input  logic             ppcEnCfg,
  input  logic             ppcActiveHighCfg,
  input  logic             bigEndianCfg,
  output logic             waitDone,
  output logic             phyRst,
  output logic             coreRst,
  output logic             bridgeRst,
  output logic             divRst,
  output logic [DIV_W-1:0] divSel,
  output logic             hostClkEn,
  output logic [REF_W-1:0] refSel,
  output logic             sscEn,
  output logic             refSspEn,
  output logic             hsPwrEn,
  output logic             ssPwrEn,
  output logic             ppcEn,
  output logic             ppcActiveHigh,
  output logic             ifClkEn,
  output logic             devMode,
  output logic             bigEndian,
  output logic             seqDone,
  output logic             seqError
);

  localparam int CNT_W = $clog2(WAIT_CYCLES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WAIT_CYCLES - 1);

  logic [CNT_W-1:0] waitCnt;

  assign waitDone = cmd.cntWait && ctrlClkStb && (waitCnt == LAST_CNT);

  // Wait counter advances only on controller-clock strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (cmd.clrWait) begin
      waitCnt <= '0;
    end else if (cmd.cntWait && ctrlClkStb && !waitDone) begin
      waitCnt <= waitCnt + CNT_W'(1);
    end
  end

  // Domain resets
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyRst    <= 1'b1;
      coreRst   <= 1'b1;
      bridgeRst <= 1'b1;
    end else begin
      if (cmd.assertAll) begin
        phyRst    <= 1'b1;
        coreRst   <= 1'b1;
        bridgeRst <= 1'b1;
      end
      if (cmd.relBridge) bridgeRst <= 1'b0;
      if (cmd.relCore)   coreRst   <= 1'b0;
      if (cmd.relPhy)    phyRst    <= 1'b0;
    end
  end

  // Clock divider and reference clocking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divRst    <= 1'b0;
      divSel    <= '0;
      hostClkEn <= 1'b0;
      refSel    <= '0;
      sscEn     <= 1'b0;
      refSspEn  <= 1'b0;
      hsPwrEn   <= 1'b0;
      ssPwrEn   <= 1'b0;
    end else begin
      if (cmd.setDivRst) divRst <= 1'b1;
      if (cmd.relDiv)    divRst <= 1'b0;
      if (cmd.applyDiv) begin
        divSel    <= divSelCfg;
        hostClkEn <= 1'b1;
      end
      if (cmd.applyPwr) begin
        refSel   <= refSelCfg;
        sscEn    <= 1'b1;
        refSspEn <= 1'b1;
        hsPwrEn  <= 1'b1;
        ssPwrEn  <= 1'b1;
      end
    end
  end

  // Host-side configuration and status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ppcEn         <= 1'b0;
      ppcActiveHigh <= 1'b0;
      ifClkEn       <= 1'b0;
      devMode       <= 1'b1;
      bigEndian     <= 1'b0;
      seqDone       <= 1'b0;
      seqError      <= 1'b0;
    end else begin
      if (cmd.applyPpc) begin
        ppcEn         <= ppcEnCfg;
        ppcActiveHigh <= ppcActiveHighCfg;
      end
      if (cmd.applyHost) begin
        ifClkEn <= 1'b1;
        devMode <= 1'b0;
      end
      if (cmd.applyEndian) bigEndian <= bigEndianCfg;
      seqDone <= cmd.relPhy;
      if (cmd.clrErr)      seqError <= 1'b0;
      else if (cmd.setErr) seqError <= 1'b1;
    end
  end

  // R2: the three domain resets are raised together
  a_r2_resets_together: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bridgeRst) |-> (phyRst && coreRst));

  // R4: power and clocking are on before the first reset release
  a_r4_power_before_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bridgeRst) |-> (hsPwrEn && ssPwrEn && sscEn && refSspEn && !divRst && coreRst && phyRst));

  // R7: core leaves reset only after the bridge
  a_r7_core_after_bridge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreRst) |-> (!bridgeRst && phyRst));

  // R9: PHY leaves reset last, in host mode, with the done pulse
  a_r9_phy_last: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phyRst) |-> (!coreRst && ifClkEn && !devMode && seqDone));

  // R10: an error leaves every domain in reset
  a_r10_error_holds_resets: assert property (@(posedge clk) disable iff (!rstN)
    seqError |-> (phyRst && coreRst && bridgeRst));

  // R5: wait counter never passes its last value
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= LAST_CNT);

endmodule

// File: rtl/usb_host_bringup_seq.sv
module usb_host_bringup_seq
  import pwrseq_pkg::*;
#(
  parameter int DIV_W       = 3,
  parameter int REF_W       = 2,
  parameter int WAIT_CYCLES = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             ctrlClkStb,
  input  logic             divReady,
  input  logic [DIV_W-1:0] divSelCfg,
  input  logic [REF_W-1:0] refSelCfg,
  input  logic             ppcEnCfg,
  input  logic             ppcActiveHighCfg,
  input  logic             bigEndianCfg,
  output logic             phyRst,
  output logic             coreRst,
  output logic             bridgeRst,
  output logic             divRst,
  output logic [DIV_W-1:0] divSel,
  output logic             hostClkEn,
  output logic [REF_W-1:0] refSel,
  output logic             sscEn,
  output logic             refSspEn,
  output logic             hsPwrEn,
  output logic             ssPwrEn,
  output logic             ppcEn,
  output logic             ppcActiveHigh,
  output logic             ifClkEn,
  output logic             devMode,
  output logic             bigEndian,
  output logic             seqDone,
  output logic             seqError
);

  seq_cmd_t seqCmd;
  logic     waitDone;

  pwrseq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .divReady   (divReady),
    .waitDone   (waitDone),
    .cmd        (seqCmd)
  );

  pwrseq_dp #(
    .DIV_W       (DIV_W),
    .REF_W       (REF_W),
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_dp (
    .clk              (clk),
    .rstN             (rstN),
    .cmd              (seqCmd),
    .ctrlClkStb       (ctrlClkStb),
    .divSelCfg        (divSelCfg),
    .refSelCfg        (refSelCfg),
    .ppcEnCfg         (ppcEnCfg),
    .ppcActiveHighCfg (ppcActiveHighCfg),
    .bigEndianCfg     (bigEndianCfg),
    .waitDone         (waitDone),
    .phyRst           (phyRst),
    .coreRst          (coreRst),
    .bridgeRst        (bridgeRst),
    .divRst           (divRst),
    .divSel           (divSel),
    .hostClkEn        (hostClkEn),
    .refSel           (refSel),
    .sscEn            (sscEn),
    .refSspEn         (refSspEn),
    .hsPwrEn          (hsPwrEn),
    .ssPwrEn          (ssPwrEn),
    .ppcEn            (ppcEn),
    .ppcActiveHigh    (ppcActiveHigh),
    .ifClkEn          (ifClkEn),
    .devMode          (devMode),
    .bigEndian        (bigEndian),
    .seqDone          (seqDone),
    .seqError         (seqError)
  );

endmodule

// File: tb/usb_host_bringup_seq_tb.sv
`timescale 1ns/1ps
module usb_host_bringup_seq_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic       ctrlClkStb = 1'b0;
  logic       divReady = 1'b1;
  logic [2:0] divSelCfg = 3'd0;
  logic [1:0] refSelCfg = 2'd0;
  logic       ppcEnCfg = 1'b0;
  logic       ppcActiveHighCfg = 1'b0;
  logic       bigEndianCfg = 1'b0;

  logic       phyRst, coreRst, bridgeRst, divRst, hostClkEn;
  logic [2:0] divSel;
  logic [1:0] refSel;
  logic       sscEn, refSspEn, hsPwrEn, ssPwrEn, ppcEn, ppcActiveHigh;
  logic       ifClkEn, devMode, bigEndian, seqDone, seqError;

  usb_host_bringup_seq u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .ctrlClkStb(ctrlClkStb),
    .divReady(divReady), .divSelCfg(divSelCfg), .refSelCfg(refSelCfg),
    .ppcEnCfg(ppcEnCfg), .ppcActiveHighCfg(ppcActiveHighCfg), .bigEndianCfg(bigEndianCfg),
    .phyRst(phyRst), .coreRst(coreRst), .bridgeRst(bridgeRst), .divRst(divRst),
    .divSel(divSel), .hostClkEn(hostClkEn), .refSel(refSel), .sscEn(sscEn),
    .refSspEn(refSspEn), .hsPwrEn(hsPwrEn), .ssPwrEn(ssPwrEn), .ppcEn(ppcEn),
    .ppcActiveHigh(ppcActiveHigh), .ifClkEn(ifClkEn), .devMode(devMode),
    .bigEndian(bigEndian), .seqDone(seqDone), .seqError(seqError)
  );

  always #2.5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;

  task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, nm, act, exp, $time);
    end
  endtask

  // Strobe generator: 0 = every cycle, 1 = every third, 2 = pseudo-random
  int stbMode = 0;
  int stbPhase = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    stbPhase = (stbPhase + 1) % 3;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (stbMode)
      0: ctrlClkStb <= 1'b1;
      1: ctrlClkStb <= (stbPhase == 0);
      default: ctrlClkStb <= lfsr[0];
    endcase
  end

  // Behavioural reference: a step index walked through the requirement order
  int step = 0;
  int strobesSeen = 0;
  logic mPhy, mCore, mBr, mDivRst, mHclk, mSsc, mRefSsp, mHs, mSs;
  logic mPpcEn, mPpcHi, mIfClk, mDev, mEnd, mDone, mErr;
  logic [2:0] mDivSel;
  logic [1:0] mRefSel;

  // R5 direct measurement
  bit   r5Counting = 0;
  int   r5Strobes = 0;
  logic prevHs = 0, prevBr = 1;

  task automatic modelReset();
    step = 0; strobesSeen = 0;
    mPhy = 1; mCore = 1; mBr = 1; mDivRst = 0; mDivSel = 0; mHclk = 0;
    mRefSel = 0; mSsc = 0; mRefSsp = 0; mHs = 0; mSs = 0;
    mPpcEn = 0; mPpcHi = 0; mIfClk = 0; mDev = 1; mEnd = 0; mDone = 0; mErr = 0;
  endtask

  task automatic waitStep(int nextStep);
    if (ctrlClkStb) begin
      strobesSeen++;
      if (strobesSeen == 10) step = nextStep;
    end
  endtask

  task automatic modelStep();
    mDone = 0;
    case (step)
      0: if (startPulse) begin mErr = 0; step = 1; end      // R2
      1: begin mPhy = 1; mCore = 1; mBr = 1; step = 2; end  // R2
      2: begin mDivRst = 1; step = 3; end                   // R3
      3: begin mDivSel = divSelCfg; mHclk = 1; step = 4; end
      4: if (divReady) step = 5; else begin mErr = 1; step = 0; end  // R10
      5: begin mDivRst = 0; step = 6; end
      6: begin mRefSel = refSelCfg; mSsc = 1; mRefSsp = 1; mHs = 1; mSs = 1;
               strobesSeen = 0; step = 7; end               // R4
      7: waitStep(8);                                       // R5
      8: begin mBr = 0; strobesSeen = 0; step = 9; end      // R6
      9: waitStep(10);
      10: begin mPpcEn = ppcEnCfg; mPpcHi = ppcActiveHighCfg; step = 11; end // R7
      11: begin mCore = 0; strobesSeen = 0; step = 12; end
      12: waitStep(13);
      13: begin mIfClk = 1; mDev = 0; step = 14; end        // R8
      14: begin mEnd = bigEndianCfg; step = 15; end         // R9
      15: begin mPhy = 0; mDone = 1; step = 0; end
      default: step = 0;
    endcase
  endtask

  function automatic string tag(string t);
    return (rstN === 1'b0) ? "R1" : t;
  endfunction

  always @(posedge clk) begin
    logic stbAtEdge;
    stbAtEdge = ctrlClkStb;
    if (!rstN) modelReset();
    else       modelStep();
    #1;
    if (!finished) begin
      cycles++;
      chk(tag("R9"),  "phyRst",        phyRst,        mPhy);
      chk(tag("R7"),  "coreRst",       coreRst,       mCore);
      chk(tag("R6"),  "bridgeRst",     bridgeRst,     mBr);
      chk(tag("R3"),  "divRst",        divRst,        mDivRst);
      chk(tag("R3"),  "divSel",        divSel,        mDivSel);
      chk(tag("R3"),  "hostClkEn",     hostClkEn,     mHclk);
      chk(tag("R4"),  "refSel",        refSel,        mRefSel);
      chk(tag("R4"),  "sscEn",         sscEn,         mSsc);
      chk(tag("R4"),  "refSspEn",      refSspEn,      mRefSsp);
      chk(tag("R4"),  "hsPwrEn",       hsPwrEn,       mHs);
      chk(tag("R4"),  "ssPwrEn",       ssPwrEn,       mSs);
      chk(tag("R7"),  "ppcEn",         ppcEn,         mPpcEn);
      chk(tag("R7"),  "ppcActiveHigh", ppcActiveHigh, mPpcHi);
      chk(tag("R8"),  "ifClkEn",       ifClkEn,       mIfClk);
      chk(tag("R8"),  "devMode",       devMode,       mDev);
      chk(tag("R9"),  "bigEndian",     bigEndian,     mEnd);
      chk(tag("R9"),  "seqDone",       seqDone,       mDone);
      chk(tag("R10"), "seqError",      seqError,      mErr);
      // R5: count strobes between the power step and the bridge release
      if (rstN) begin
        if (prevBr && !bridgeRst && r5Counting) begin
          chk("R5", "strobesBeforeBridgeRelease", r5Strobes, 10);
          r5Counting = 0;
        end else if (r5Counting && stbAtEdge) begin
          r5Strobes++;
        end
        if (!prevHs && hsPwrEn) begin
          r5Counting = 1; r5Strobes = 0;
        end
      end
      prevHs = hsPwrEn;
      prevBr = bridgeRst;
    end
  end

  task automatic pulseStart();
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (step == 0) break;
    end
  endtask

  task automatic setCfg(logic [2:0] d, logic [1:0] r, logic pe, logic ph, logic be);
    divSelCfg = d; refSelCfg = r; ppcEnCfg = pe; ppcActiveHighCfg = ph; bigEndianCfg = be;
  endtask

  task automatic finish();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    // R1: reset values observed during reset
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // Run A: dense strobes, big endian, active-high port power
    stbMode = 0;
    setCfg(3'd3, 2'd2, 1'b1, 1'b1, 1'b1);
    pulseStart();
    @(negedge clk);
    chk("R2", "allResetsAfterStart", {phyRst, coreRst, bridgeRst}, 3'b111);
    waitIdle();
    chk("R9", "phyReleasedAfterRunA", phyRst, 1'b0);

    // Run B: sparse strobes, stray starts mid-sequence (R11), little endian
    stbMode = 1;
    setCfg(3'd5, 2'd1, 1'b1, 1'b0, 1'b0);
    pulseStart();   // R12: rerun after completion
    repeat (3) @(negedge clk);
    chk("R12", "resetsReassertedOnRerun", {phyRst, coreRst, bridgeRst}, 3'b111);
    repeat (6) @(negedge clk);
    pulseStart();   // R11: ignored while running
    repeat (25) @(negedge clk);
    pulseStart();   // R11: ignored while running
    waitIdle();
    chk("R9", "littleEndianApplied", bigEndian, 1'b0);

    // Run C: divider check fails (R10)
    stbMode = 2;
    divReady = 1'b0;
    pulseStart();
    waitIdle();
    divReady = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10", "errorSticky", seqError, 1'b1);
    chk("R10", "resetsHeldAfterError", {phyRst, coreRst, bridgeRst, divRst}, 4'b1111);

    // Run D: restart after error, random strobes, port power off (R12)
    setCfg(3'd7, 2'd3, 1'b0, 1'b1, 1'b1);
    pulseStart();
    chk("R12", "errorClearedOnRestart", seqError, 1'b0);
    waitIdle();
    chk("R8", "hostModeAfterRunD", devMode, 1'b0);
    repeat (5) @(negedge clk);
    finish();
  end

endmodule